// File: doc/BRIEF.md
# Indirect Extended-Register Access Bridge

This block sits behind a Clause 22 style management register port. It reaches a larger extended register space through two window registers. The control window sits at management address 0x0d and the data window at 0x0e. Software first selects address mode in the control window and writes a register number into the data window. It then switches the control window to one of the data functions and reads or writes the chosen extended register through the data window.

The bridge holds the function code, the device address and a 16-bit register pointer. Two of the data functions advance the pointer after each access, so software can walk a block of registers without reloading the address. The extended space is a small bank of byte-wide LED configuration registers. They belong to device address 0x1f and cover registers 0x1e0 to 0x1e9. Each register comes out of reset with its own value.

Requests arrive one per cycle. A read answers on the following cycle with a strobe and the read data. Writes produce no response.

Top module: `mmd_bridge`

## Requirements
- R1: After reset the control window reads 0x0000, the pointer is 0x0000, and the ten extended registers 0x1e0..0x1e9 hold 0xC5, 0x67, 0x70, 0x03, 0x20, 0x00, 0x40, 0x00, 0x40, 0x20 in address order.
- R2: A write to address 0x0d stores bits 15:14 as the function and bits 4:0 as the device address. A read of 0x0d returns these two fields in the same positions, with bits 13:5 reading zero.
- R3: In address mode (function 0), a write to 0x0e loads the pointer and a read of 0x0e returns the pointer.
- R4: With function 1, 2 or 3 and device 0x1f, a write to 0x0e stores bits 7:0 in the extended register selected by the pointer. A read of 0x0e returns that register in bits 7:0, with bits 15:8 reading zero.
- R5: With function 2, every read and every write of 0x0e advances the pointer by one after the access. The access itself uses the pointer value from before the increment.
- R6: With function 3, each write of 0x0e advances the pointer by one, and reads of 0x0e leave the pointer unchanged.
- R7: With function 1, data accesses never change the pointer.
- R8: The pointer wraps from 0xFFFF to 0x0000 on post-increment.
- R9: When the device address is not 0x1f, data reads return 0x0000 and data writes change no register. The pointer still follows R5 to R7.
- R10: In device 0x1f, a pointer outside 0x1e0..0x1e9 reads 0x0000, and a write there changes no register.
- R11: A read request gets exactly one response, with rsp_valid_o high in the cycle after the request. A write request gets no response.
- R12: Management addresses other than 0x0d and 0x0e read 0x0000, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Management request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Management register address |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Read response strobe, one cycle after a read request |
| rsp_rdata_o | output | 16 | Read response data |

## Verification
The bench targets the pointer side effects of each data function. It reads a register twice under the write-only increment function; a design that increments on both reads and writes would return the next register on the second read. It walks the pointer through the LED block with the read/write increment function and reads the pointer back in address mode, which exposes an increment applied before the access or skipped on one direction. It also places the pointer at 0xFFFF to catch a missing wrap, and just outside both ends of the register block to catch aliasing or an off-by-one range check. Writes to a foreign device address, followed by reads of the same register through device 0x1f, expose a missing device-address match.

// File: rtl/mmd_bridge_pkg.sv
`timescale 1ns/1ps
package mmd_bridge_pkg;
  localparam int REG_W = 16;
  localparam int MA_W  = 5;
  localparam int DEV_W = 5;

  typedef enum logic [1:0] {
    FN_ADDR        = 2'd0,
    FN_DATA        = 2'd1,
    FN_DATA_INC_RW = 2'd2,
    FN_DATA_INC_WR = 2'd3
  } mmd_fn_e;

  // power-on value of LED configuration register at offset idx
  function automatic logic [7:0] led_reset_val(input int idx);
    case (idx)
      0: return 8'hC5;
      1: return 8'h67;
      2: return 8'h70;
      3: return 8'h03;
      4: return 8'h20;
      5: return 8'h00;
      6: return 8'h40;
      7: return 8'h00;
      8: return 8'h40;
      9: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/mmd_win_ctrl.sv
`timescale 1ns/1ps
module mmd_win_ctrl
  import mmd_bridge_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             data_we_i,
  input  logic             data_re_i,
  input  logic [REG_W-1:0] wdata_i,
  output mmd_fn_e          fn_o,
  output logic [DEV_W-1:0] dev_o,
  output logic [PTR_W-1:0] ptr_o
);
  mmd_fn_e          fn_q;
  logic [DEV_W-1:0] dev_q;
  logic [PTR_W-1:0] ptr_q;
  logic             inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fn_q  <= FN_ADDR;
      dev_q <= '0;
    end else if (ctrl_we_i) begin
      fn_q  <= mmd_fn_e'(wdata_i[REG_W-1 -: 2]);
      dev_q <= wdata_i[DEV_W-1:0];
    end
  end

  always_comb begin
    inc = 1'b0;
    unique case (fn_q)
      FN_DATA_INC_RW: inc = data_we_i | data_re_i;
      FN_DATA_INC_WR: inc = data_we_i;
      default:        inc = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ptr_q <= '0;
    else if (data_we_i && fn_q == FN_ADDR) ptr_q <= wdata_i[PTR_W-1:0];
    else if (inc)                         ptr_q <= ptr_q + 1'b1;
  end

  assign fn_o  = fn_q;
  assign dev_o = dev_q;
  assign ptr_o = ptr_q;
endmodule

// File: rtl/mmd_ext_store.sv
`timescale 1ns/1ps
module mmd_ext_store
  import mmd_bridge_pkg::*;
#(
  parameter int          PTR_W    = 16,
  parameter int          DATA_W   = 8,
  parameter int          NUM_REGS = 10,
  parameter logic [15:0] BASE     = 16'h01E0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [PTR_W-1:0]  offs;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  assign offs  = addr_i - PTR_W'(BASE);
  assign hit_o = (addr_i >= PTR_W'(BASE)) && (offs < PTR_W'(NUM_REGS));
  assign idx   = offs[IDX_W-1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= DATA_W'(led_reset_val(g));
      else if (we_i && hit_o && idx == IDX_W'(g))   regs_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit_o && idx == IDX_W'(i)) rdata_o = regs_q[i];
  end
endmodule

// File: rtl/mmd_bridge.sv
`timescale 1ns/1ps
module mmd_bridge
  import mmd_bridge_pkg::*;
#(
  parameter logic [MA_W-1:0]  CTRL_ADDR = 5'h0D,
  parameter logic [MA_W-1:0]  DATA_ADDR = 5'h0E,
  parameter logic [DEV_W-1:0] DEV_ID    = 5'h1F,
  parameter int               DATA_W    = 8,
  parameter int               NUM_REGS  = 10,
  parameter logic [15:0]      BASE      = 16'h01E0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [MA_W-1:0]  req_addr_i,
  input  logic [REG_W-1:0] req_wdata_i,
  output logic             rsp_valid_o,
  output logic [REG_W-1:0] rsp_rdata_o
);
  localparam int PTR_W = REG_W;
  localparam int RSV_W = REG_W - 2 - DEV_W;

  mmd_fn_e           fn_q;
  logic [DEV_W-1:0]  dev_q;
  logic [PTR_W-1:0]  ptr_q;
  logic              ctrl_we, data_we, data_re, rd_req;
  logic              dev_hit, st_hit, st_we;
  logic [DATA_W-1:0] st_rdata;
  logic [REG_W-1:0]  rd_mux;
  logic              rsp_valid_q;
  logic [REG_W-1:0]  rsp_rdata_q;

  assign rd_req  = req_valid_i && !req_write_i;
  assign ctrl_we = req_valid_i && req_write_i && req_addr_i == CTRL_ADDR;
  assign data_we = req_valid_i && req_write_i && req_addr_i == DATA_ADDR;
  assign data_re = rd_req && req_addr_i == DATA_ADDR && fn_q != FN_ADDR;
  assign dev_hit = dev_q == DEV_ID;
  assign st_we   = data_we && fn_q != FN_ADDR && dev_hit;

  mmd_win_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_we_i(ctrl_we),
    .data_we_i(data_we),
    .data_re_i(data_re),
    .wdata_i  (req_wdata_i),
    .fn_o     (fn_q),
    .dev_o    (dev_q),
    .ptr_o    (ptr_q)
  );

  mmd_ext_store #(
    .PTR_W   (PTR_W),
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .BASE    (BASE)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (st_we),
    .addr_i (ptr_q),
    .wdata_i(req_wdata_i[DATA_W-1:0]),
    .hit_o  (st_hit),
    .rdata_o(st_rdata)
  );

  always_comb begin
    rd_mux = '0;
    if (req_addr_i == CTRL_ADDR)
      rd_mux = {fn_q, {RSV_W{1'b0}}, dev_q};
    else if (req_addr_i == DATA_ADDR) begin
      if (fn_q == FN_ADDR)        rd_mux = ptr_q;
      else if (dev_hit && st_hit) rd_mux = REG_W'(st_rdata);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_req;
      if (rd_req) rsp_rdata_q <= rd_mux;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
endmodule

// File: rtl/mmd_bridge_chk.sv
`timescale 1ns/1ps
module mmd_bridge_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_write_i,
  input logic [4:0]  req_addr_i,
  input logic [15:0] req_wdata_i,
  input logic        rsp_valid_o,
  input logic [15:0] rsp_rdata_o,
  input logic [1:0]  fn_i,
  input logic [15:0] ptr_i
);
  logic rd, wr_data, rd_data, rd_ctrl;
  assign rd      = req_valid_i && !req_write_i;
  assign wr_data = req_valid_i && req_write_i && req_addr_i == 5'h0E;
  assign rd_data = rd && req_addr_i == 5'h0E;
  assign rd_ctrl = rd && req_addr_i == 5'h0D;

  p_rsp_after_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rsp_valid_o);
  p_no_rsp_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rsp_valid_o);
  p_ctrl_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |=> rsp_rdata_o[13:5] == 9'd0);
  p_ptr_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && fn_i == 2'd0) |=> ptr_i == $past(req_wdata_i));
  p_ptr_inc_rw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_data || rd_data) && fn_i == 2'd2) |=> ptr_i == $past(ptr_i) + 16'd1);
  p_ptr_inc_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && fn_i == 2'd3) |=> ptr_i == $past(ptr_i) + 16'd1);
  p_ptr_hold_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && fn_i == 2'd3) |=> $stable(ptr_i));
  p_ptr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_data || rd_data) && fn_i == 2'd1) |=> $stable(ptr_i));
  p_data_hi_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && fn_i != 2'd0) |=> rsp_rdata_o[15:8] == 8'd0);
endmodule

bind mmd_bridge mmd_bridge_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .fn_i       (fn_q),
  .ptr_i      (ptr_q)
);

// File: tb/tb_mmd_bridge.sv
`timescale 1ns/1ps
module tb_mmd_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  mmd_bridge dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_valid_i(req_valid),
    .req_write_i(req_write),
    .req_addr_i (req_addr),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata)
  );

  localparam logic [4:0] CTL = 5'h0D;
  localparam logic [4:0] DAT = 5'h0E;

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p, input logic [15:0] ctl_after);
    wr(CTL, 16'h001F);
    wr(DAT, p);
    wr(CTL, ctl_after);
  endtask

  // monitor: compare each response with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response: actual %h expected none", rsp_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(CTL, 16'h0000, "R1 ctrl reset");
    rd(DAT, 16'h0000, "R1 ptr reset");
    set_ptr(16'h01E0, 16'h401F);
    rd(DAT, 16'h00C5, "R1 reg 1e0 reset");
    // R4 write/read, upper byte dropped
    wr(DAT, 16'hABCD);
    rd(DAT, 16'h00CD, "R4 data write readback");
    // R2 control readback, reserved bits zero
    rd(CTL, 16'h401F, "R2 ctrl readback");
    wr(CTL, 16'hFFFF);
    rd(CTL, 16'hC01F, "R2 reserved bits read zero");
    // R5 increment on read and write
    set_ptr(16'h01E2, 16'h801F);
    rd(DAT, 16'h0070, "R5 first read 1e2");
    rd(DAT, 16'h0003, "R5 read after inc 1e3");
    wr(DAT, 16'h0011);
    wr(CTL, 16'h001F);
    rd(DAT, 16'h01E5, "R5 ptr after read,read,write");
    // R6 increment on write only
    set_ptr(16'h01E4, 16'hC01F);
    rd(DAT, 16'h0011, "R6 read 1e4");
    rd(DAT, 16'h0011, "R6 second read no inc");
    wr(DAT, 16'h0022);
    wr(DAT, 16'h0033);
    wr(CTL, 16'h001F);
    rd(DAT, 16'h01E6, "R6 ptr after two writes");
    set_ptr(16'h01E4, 16'h401F);
    rd(DAT, 16'h0022, "R6 first write landed 1e4");
    // R7 plain data mode holds pointer
    rd(DAT, 16'h0022, "R7 repeat read");
    wr(DAT, 16'h0044);
    rd(DAT, 16'h0044, "R7 write same reg");
    wr(CTL, 16'h001F);
    rd(DAT, 16'h01E4, "R7 ptr unchanged");
    // R8 wrap
    set_ptr(16'hFFFF, 16'h801F);
    rd(DAT, 16'h0000, "R8 read at 0xffff");
    wr(CTL, 16'h001F);
    rd(DAT, 16'h0000, "R8 ptr wrapped");
    // R9 foreign device
    wr(CTL, 16'h0003);
    wr(DAT, 16'h01E0);
    wr(CTL, 16'h4003);
    wr(DAT, 16'h0055);
    rd(DAT, 16'h0000, "R9 foreign device read");
    wr(CTL, 16'h401F);
    rd(DAT, 16'h00CD, "R9 foreign write ignored");
    // R10 range edges
    set_ptr(16'h01EA, 16'h401F);
    wr(DAT, 16'h0077);
    rd(DAT, 16'h0000, "R10 above range");
    set_ptr(16'h01DF, 16'h401F);
    wr(DAT, 16'h0066);
    rd(DAT, 16'h0000, "R10 below range");
    set_ptr(16'h01E9, 16'h401F);
    rd(DAT, 16'h0020, "R10 last reg untouched");
    set_ptr(16'h01E0, 16'h401F);
    rd(DAT, 16'h00CD, "R10 first reg untouched");
    // R12 other addresses
    wr(5'h05, 16'hFFFF);
    rd(5'h05, 16'h0000, "R12 other addr read");
    rd(5'h00, 16'h0000, "R12 addr 0 read");
    rd(CTL, 16'h401F, "R12 ctrl unchanged");
    rd(DAT, 16'h00CD, "R12 data unchanged");
    repeat (4) @(negedge clk);
    // R11 every read answered exactly once
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending responses: actual %0d expected 0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule